// File: doc/BRIEF.md
# Two-Channel Cycle-Stealing DMA Controller

This block moves data between memory locations on a bus it shares with a CPU. It holds the bus at a higher priority than the processor. Each transfer takes the bus for two cycles, a read followed by a write, and then gives it back. Each of the two channels holds the following state:

- a 20-bit source base;
- a 20-bit destination base;
- a 20-bit running offset, which acts as the forward pointer;
- a 16-bit remaining-transfer counter;
- a 16-bit reload value.

A transfer moves either one byte or one 16-bit word.

Software sets up a channel through a small write port. A channel's request can come from two places: a write to that channel's software-request field, or a rising edge on one of the interrupt lines, chosen per channel. The block only observes the interrupt lines and never drives them. Each channel keeps a single pending bit, so requests that arrive while one is already waiting are merged into it.

A sequencer has three states: `SQ_IDLE`, `SQ_READ` and `SQ_WRITE`.

- **GRANT** (`SQ_IDLE` to `SQ_READ`): taken when any channel is pending. Channel 0 wins if both are pending. The chosen channel's pending bit is cleared.
- **STEAL** (`SQ_READ` to `SQ_WRITE`): always taken. The read data is captured in a 16-bit latch.
- **RELEASE** (`SQ_WRITE` to `SQ_IDLE`): always taken. The channel's counter and offset are updated.
- **HOLD** (`SQ_IDLE` to `SQ_IDLE`): taken when nothing is pending.

Because the sequencer always returns to `SQ_IDLE`, the CPU gets at least one free cycle between two transfers.

Top module: `dma2_steal`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr`, `cpu_stall` and `done` are all low.
- R2: Each serviced request causes a read cycle followed, on the very next cycle, by a write cycle.
  - The write data equals the data read.
  - In byte mode (`mem_byte`=1), the written data is the low byte of the read data, zero-extended.
- R3: `cpu_stall` is high in every read cycle and every write cycle. It is low in the cycle after a write.
- R4: A channel whose enable bit is 0 ignores both software requests and interrupt edges.
- R5: An interrupt request counts only when all of the following hold:
  - the channel's interrupt-enable bit is 1;
  - the edge is on the line the channel selects;
  - the line goes from 0 to 1.

  A line held high produces one request. Edges on other lines have no effect.
- R6: The read address is source base plus offset if source increment is set, otherwise the base alone. The write address is formed the same way from the destination base and destination increment. The offset steps by 1 per byte transfer and by 2 per word transfer.
- R7: Requests that arrive while the channel is already pending merge into one. Three software requests on three consecutive cycles therefore yield exactly two transfers.
- R8: When both channels become pending in the same cycle, channel 0's transfer is performed first.
- R9: The transfer counter expires on the write cycle of the transfer made when it holds 1 (a written 0 also counts as 1).
  - On expiry, that channel's `done` bit is high during that write cycle only.
  - In single mode, expiry clears the enable bit, so later requests are ignored.
- R10: In repeat mode, expiry reloads the counter from the reload value and resets the offset to 0, so the addresses restart from the bases.
- R11: A register write applies to the channel given by `cfg_ch` and the field given by `cfg_field`:

  | `cfg_field` | Effect |
  |---|---|
  | 0 | Writes the source base and clears the offset. |
  | 1 | Writes the destination base and clears the offset. |
  | 2 | Writes the counter and the reload value from bits 15:0, and clears the offset. |
  | 3 | Writes the control bits listed below. |
  | 4 | Raises a software request. |

  Control bits written through field 3:

  | Bit(s) | Meaning |
  |---|---|
  | 0 | Enable |
  | 1 | Word mode |
  | 2 | Source increment |
  | 3 | Destination increment |
  | 4 | Repeat mode |
  | 5 | Interrupt enable |
  | 7:6 | Interrupt line select |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel addressed by the write |
| cfg_field | input | 3 | Field code of the write |
| cfg_wdata | input | 20 | Write data |
| irq_lines | input | 4 | Interrupt request lines (observed only) |
| mem_addr | output | 20 | Bus address |
| mem_rd | output | 1 | Read cycle |
| mem_wr | output | 1 | Write cycle |
| mem_byte | output | 1 | 1 for a byte transfer, 0 for a word |
| mem_wdata | output | 16 | Write data from the latch |
| mem_rdata | input | 16 | Read data from memory |
| cpu_stall | output | 1 | CPU must not use the bus |
| done | output | 2 | Per-channel expiry pulse |

## Verification
A wrong offset or a wrong increment selection shows up on `mem_addr` during the very next read or write cycle of that channel. A corrupted latch shows up as wrong `mem_wdata` one cycle after the read. A miscounted transfer counter cannot be seen until expiry: `done` then appears on the wrong transfer, and in single mode further requests are either lost or still serviced. The bench therefore counts bus cycles per request burst, and issues requests after expiry to expose such errors. Pending-bit errors appear as extra or missing transfers a few cycles after a burst of requests.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_e;

    localparam logic [2:0] FLD_SRC   = 3'd0;
    localparam logic [2:0] FLD_DST   = 3'd1;
    localparam logic [2:0] FLD_CNT   = 3'd2;
    localparam logic [2:0] FLD_CTRL  = 3'd3;
    localparam logic [2:0] FLD_SWREQ = 3'd4;

    localparam int CB_EN    = 0;
    localparam int CB_WORD  = 1;
    localparam int CB_SINC  = 2;
    localparam int CB_DINC  = 3;
    localparam int CB_RPT   = 4;
    localparam int CB_IRQEN = 5;
    localparam int CB_SEL   = 6;

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int NIRQ   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [NIRQ-1:0]   irq_lines,
    input  logic              grant,
    input  logic              xfer_end,
    output logic              pend_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              word_o,
    output logic              done_o
);

    localparam int SEL_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [ADDR_W-1:0] src_q, dst_q, fwd_q;
    logic [CNT_W-1:0]  cnt_q, reload_q;
    logic              en_q, word_q, sinc_q, dinc_q, rpt_q, irqen_q;
    logic [SEL_W-1:0]  sel_q;
    logic [NIRQ-1:0]   irq_q;
    logic              pend_q;

    logic              last, expire_off, en_nxt, req_ev, pend_nxt, ctrl_wr;
    logic [NIRQ-1:0]   irq_edge;
    logic [ADDR_W-1:0] step;

    assign ctrl_wr    = wr_en && (wr_field == FLD_CTRL);
    assign last       = (cnt_q <= CNT_W'(1));
    assign expire_off = xfer_end && last && !rpt_q;
    assign step       = word_q ? ADDR_W'(2) : ADDR_W'(1);
    assign irq_edge   = irq_lines & ~irq_q;

    always_comb begin
        en_nxt = ctrl_wr ? wr_data[CB_EN] : en_q;
        if (expire_off) begin
            en_nxt = 1'b0;
        end
        req_ev = (wr_en && (wr_field == FLD_SWREQ))
               || (irqen_q && irq_edge[sel_q]);
        if (en_q && en_nxt) begin
            pend_nxt = (pend_q && !grant) || req_ev;
        end else begin
            pend_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            fwd_q    <= '0;
            cnt_q    <= '0;
            reload_q <= '0;
            en_q     <= 1'b0;
            word_q   <= 1'b0;
            sinc_q   <= 1'b0;
            dinc_q   <= 1'b0;
            rpt_q    <= 1'b0;
            irqen_q  <= 1'b0;
            sel_q    <= '0;
            irq_q    <= '0;
            pend_q   <= 1'b0;
        end else begin
            irq_q  <= irq_lines;
            pend_q <= pend_nxt;
            en_q   <= en_nxt;
            if (wr_en) begin
                unique case (wr_field)
                    FLD_SRC: begin
                        src_q <= wr_data;
                        fwd_q <= '0;
                    end
                    FLD_DST: begin
                        dst_q <= wr_data;
                        fwd_q <= '0;
                    end
                    FLD_CNT: begin
                        cnt_q    <= wr_data[CNT_W-1:0];
                        reload_q <= wr_data[CNT_W-1:0];
                        fwd_q    <= '0;
                    end
                    FLD_CTRL: begin
                        word_q  <= wr_data[CB_WORD];
                        sinc_q  <= wr_data[CB_SINC];
                        dinc_q  <= wr_data[CB_DINC];
                        rpt_q   <= wr_data[CB_RPT];
                        irqen_q <= wr_data[CB_IRQEN];
                        sel_q   <= wr_data[CB_SEL +: SEL_W];
                    end
                    default: ;
                endcase
            end
            if (xfer_end) begin
                if (last) begin
                    if (rpt_q) begin
                        cnt_q <= reload_q;
                        fwd_q <= '0;
                    end
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    fwd_q <= fwd_q + step;
                end
            end
        end
    end

    assign pend_o    = pend_q;
    assign word_o    = word_q;
    assign done_o    = xfer_end && last;
    assign rd_addr_o = src_q + (sinc_q ? fwd_q : '0);
    assign wr_addr_o = dst_q + (dinc_q ? fwd_q : '0);

    a_r4_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pend_q);

    a_r9_single_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && last && !rpt_q && !wr_en) |=> !en_q);

    a_r10_repeat_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && last && rpt_q && !wr_en) |=> (cnt_q == reload_q && fwd_q == '0));

    a_r6_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end && !last && !wr_en) |=> (fwd_q == $past(fwd_q) + $past(step)));

endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
    import dma2_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pend,
    input  logic [ADDR_W-1:0] src_addr [NCH],
    input  logic [ADDR_W-1:0] dst_addr [NCH],
    input  logic [NCH-1:0]    word,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [NCH-1:0]    grant,
    output logic [NCH-1:0]    xfer_end,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_byte,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cpu_stall
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int HALF = DATA_W / 2;

    seq_state_e        state_q, state_nxt;
    logic [CH_W-1:0]   cur_q, pick;
    logic              any_pend;
    logic [DATA_W-1:0] latch_q;

    always_comb begin
        pick     = '0;
        any_pend = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick     = CH_W'(i);
                any_pend = 1'b1;
            end
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            SQ_IDLE:  if (any_pend) state_nxt = SQ_READ;
            SQ_READ:  state_nxt = SQ_WRITE;
            SQ_WRITE: state_nxt = SQ_IDLE;
            default:  state_nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            latch_q <= '0;
        end else begin
            if (state_q == SQ_IDLE && any_pend) begin
                cur_q <= pick;
            end
            if (state_q == SQ_READ) begin
                latch_q <= word[cur_q] ? mem_rdata
                                       : {{(DATA_W-HALF){1'b0}}, mem_rdata[HALF-1:0]};
            end
        end
    end

    always_comb begin
        grant     = '0;
        xfer_end  = '0;
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_byte  = 1'b0;
        cpu_stall = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (any_pend) grant[pick] = 1'b1;
            end
            SQ_READ: begin
                mem_addr  = src_addr[cur_q];
                mem_rd    = 1'b1;
                mem_byte  = !word[cur_q];
                cpu_stall = 1'b1;
            end
            SQ_WRITE: begin
                mem_addr       = dst_addr[cur_q];
                mem_wr         = 1'b1;
                mem_byte       = !word[cur_q];
                cpu_stall      = 1'b1;
                xfer_end[cur_q] = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_wdata = latch_q;

    a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r3_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !cpu_stall);

    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r8_low_channel_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && pend[0]) |=> (mem_rd && cur_q == '0));

endmodule

// File: rtl/dma2_steal.sv
module dma2_steal
    import dma2_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int NIRQ   = 4,
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [NIRQ-1:0]   irq_lines,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_byte,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cpu_stall,
    output logic [NCH-1:0]    done
);

    logic [NCH-1:0]    pend, grant, xfer_end, word;
    logic [ADDR_W-1:0] src_a [NCH];
    logic [ADDR_W-1:0] dst_a [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel_wr;
        assign sel_wr = cfg_we && (cfg_ch == CH_W'(g));

        dma2_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .NIRQ   (NIRQ)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel_wr),
            .wr_field  (cfg_field),
            .wr_data   (cfg_wdata),
            .irq_lines (irq_lines),
            .grant     (grant[g]),
            .xfer_end  (xfer_end[g]),
            .pend_o    (pend[g]),
            .rd_addr_o (src_a[g]),
            .wr_addr_o (dst_a[g]),
            .word_o    (word[g]),
            .done_o    (done[g])
        );
    end

    dma2_seq #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .src_addr  (src_a),
        .dst_addr  (dst_a),
        .word      (word),
        .mem_rdata (mem_rdata),
        .grant     (grant),
        .xfer_end  (xfer_end),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_byte  (mem_byte),
        .mem_wdata (mem_wdata),
        .cpu_stall (cpu_stall)
    );

    a_r1_quiet_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_rd && !mem_wr && !cpu_stall));

endmodule

// File: tb/dma2_steal_test.sv
`timescale 1ns/1ps
module dma2_steal_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_ch = '0;
    logic [2:0]  cfg_field = '0;
    logic [19:0] cfg_wdata = '0;
    logic [3:0]  irq_lines = '0;
    logic [19:0] mem_addr;
    logic        mem_rd, mem_wr, mem_byte, cpu_stall;
    logic [15:0] mem_wdata, mem_rdata;
    logic [1:0]  done;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem_addr[15:0] ^ 16'hA5C3;

    dma2_steal uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .irq_lines(irq_lines),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_byte(mem_byte),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_stall(cpu_stall), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus monitor
    logic [19:0] rd_log [0:63];
    logic [19:0] wr_log [0:63];
    int rd_n = 0, wr_n = 0;
    int done_n [2] = '{0, 0};
    logic [19:0] last_rd = '0;
    logic last_byte = 1'b0;
    bit prev_rd = 0, prev_wr = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_rd) begin
                if (rd_n < 64) rd_log[rd_n] = mem_addr;
                rd_n++;
                last_rd = mem_addr;
                last_byte = mem_byte;
                chk(cpu_stall, "R3 stall in read", 32'(cpu_stall), 1);
            end
            if (mem_wr) begin
                logic [15:0] f;
                f = last_rd[15:0] ^ 16'hA5C3;
                if (last_byte) f = {8'h00, f[7:0]};
                chk(prev_rd, "R2 write follows read", 32'(prev_rd), 1);
                chk(mem_wdata == f, "R2 write data", 32'(mem_wdata), 32'(f));
                chk(cpu_stall, "R3 stall in write", 32'(cpu_stall), 1);
                if (wr_n < 64) wr_log[wr_n] = mem_addr;
                wr_n++;
            end
            if (prev_wr) chk(!cpu_stall, "R3 release after write", 32'(cpu_stall), 0);
            for (int i = 0; i < 2; i++) begin
                if (done[i]) begin
                    done_n[i]++;
                    chk(mem_wr, "R9 done only in write cycle", 32'(mem_wr), 1);
                end
            end
            prev_rd = mem_rd;
            prev_wr = mem_wr;
        end
    end

    task automatic cfg(input int ch, input logic [2:0] fld, input logic [19:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_field = fld; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic setup(input int ch, input logic [19:0] s, input logic [19:0] d,
                         input logic [19:0] n, input logic [19:0] ctl);
        cfg(ch, 3'd0, s);
        cfg(ch, 3'd1, d);
        cfg(ch, 3'd2, n);
        cfg(ch, 3'd3, ctl);
    endtask

    initial begin
        int b, d0, d1;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!mem_rd && !mem_wr, "R1 bus idle in reset", {mem_rd, mem_wr}, 0);
        chk(!cpu_stall && done == 0, "R1 stall/done low", {cpu_stall, done}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_rd && !mem_wr && !cpu_stall && done == 0, "R1 after reset",
            {mem_rd, mem_wr, cpu_stall, done}, 0);

        // R11 encodings; R2/R6/R9: byte, both increment, single, count 3
        setup(0, 20'h10000, 20'h20000, 20'd3, 20'h0D);
        b = rd_n; d0 = done_n[0];
        for (int k = 0; k < 3; k++) begin
            cfg(0, 3'd4, 0);
            idle(6);
        end
        chk(rd_n - b == 3, "R2 one transfer per request", rd_n - b, 3);
        for (int k = 0; k < 3; k++) begin
            chk(rd_log[b+k] == 20'h10000 + k, "R6 byte src step", rd_log[b+k], 20'h10000 + k);
            chk(wr_log[b+k] == 20'h20000 + k, "R6 byte dst step", wr_log[b+k], 20'h20000 + k);
        end
        chk(done_n[0] - d0 == 1, "R9 single done pulse", done_n[0] - d0, 1);
        cfg(0, 3'd4, 0);
        idle(6);
        chk(rd_n - b == 3, "R9 disabled after expiry", rd_n - b, 3);

        // R10/R6: channel 1 word, fixed source, incrementing dest, repeat, count 2
        setup(1, 20'h0ABCD, 20'h30000, 20'd2, 20'h1B);
        b = rd_n; d1 = done_n[1];
        for (int k = 0; k < 4; k++) begin
            cfg(1, 3'd4, 0);
            idle(6);
        end
        chk(rd_n - b == 4, "R10 repeat keeps serving", rd_n - b, 4);
        for (int k = 0; k < 4; k++) begin
            chk(rd_log[b+k] == 20'h0ABCD, "R6 fixed source", rd_log[b+k], 20'h0ABCD);
            chk(wr_log[b+k] == 20'h30000 + 2*(k % 2), "R10 dest restarts, word step R6",
                wr_log[b+k], 20'h30000 + 2*(k % 2));
        end
        chk(done_n[1] - d1 == 2, "R10 done per expiry", done_n[1] - d1, 2);

        // R4: disabled channel ignores software and interrupt requests
        setup(0, 20'h01000, 20'h02000, 20'd50, 20'h2C);
        b = rd_n;
        cfg(0, 3'd4, 0);
        idle(6);
        irq_lines = 4'b0001; idle(4); irq_lines = 4'b0000; idle(6);
        chk(rd_n == b, "R4 disabled ignores requests", rd_n - b, 0);

        // R5: interrupt select line 2
        cfg(0, 3'd3, 20'hAD);
        b = rd_n;
        irq_lines = 4'b0010; idle(4); irq_lines = 4'b0000; idle(6);
        chk(rd_n == b, "R5 other line ignored", rd_n - b, 0);
        irq_lines = 4'b0100; idle(10);
        chk(rd_n - b == 1, "R5 held line gives one request", rd_n - b, 1);
        irq_lines = 4'b0000; idle(2);
        irq_lines = 4'b0100; idle(8); irq_lines = 4'b0000; idle(2);
        chk(rd_n - b == 2, "R5 second edge", rd_n - b, 2);
        chk(rd_log[b+1] == 20'h01001, "R5 second read address", rd_log[b+1], 20'h01001);

        // R7: three back-to-back software requests merge into two transfers
        setup(0, 20'h08000, 20'h09000, 20'd100, 20'h0D);
        b = rd_n;
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ch = 1'b0; cfg_field = 3'd4; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        #1 cfg_we = 1'b0;
        idle(12);
        chk(rd_n - b == 2, "R7 merged requests", rd_n - b, 2);

        // R8: both channels pending in the same cycle
        setup(0, 20'h04000, 20'h05000, 20'd10, 20'h2D);
        setup(1, 20'h06000, 20'h07000, 20'd10, 20'h2D);
        b = rd_n;
        irq_lines = 4'b0001; idle(12); irq_lines = 4'b0000; idle(2);
        chk(rd_n - b == 2, "R8 both served", rd_n - b, 2);
        chk(rd_log[b] == 20'h04000, "R8 channel 0 first", rd_log[b], 20'h04000);
        chk(rd_log[b+1] == 20'h06000, "R8 channel 1 second", rd_log[b+1], 20'h06000);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule